// File: doc/BRIEF.md
# Narrow-to-wide dual-clock FIFO pair

This block moves 32-bit words written in one clock domain to a reader in a second, unrelated clock domain that consumes them 64 bits at a time. Each accepted narrow write is sent to one of two half-width asynchronous FIFOs. A small steering controller alternates between them, so the first word of every pair lands in the low-half FIFO and the second in the high-half FIFO.

On the wide side one access pops both FIFOs in the same cycle and presents the two halves joined as one 64-bit word. The wide side reports empty until both FIFOs hold at least one entry, so a half-built word can never be taken. The narrow side sees an acknowledge for each accepted word, a full flag for the FIFO that the next write would go to, and an occupancy count in 32-bit words.

Each FIFO crosses its pointers as Gray code through two-flop synchronizers. Each reset input is asserted asynchronously and released synchronously to its own clock.

Top module: `nw_fifo_pair`

## Requirements
- R1: Counting accepted narrow writes from 0 after reset, word 2k appears as rd_data[31:0] and word 2k+1 appears as rd_data[63:32] of the k-th wide word read.
- R2: The steering alternates between the low and high FIFO on every accepted write and holds its lane when no write is accepted. At most one FIFO write enable is active per cycle.
- R3: A write is accepted when wr_en is 1 and wr_full is 0. A write attempted while wr_full is 1 is dropped: no acknowledge follows, wr_count is unchanged, and the word never appears on the read side.
- R4: wr_ack is 1 in the wr_clk cycle that follows an accepted write, and 0 otherwise.
- R5: rd_empty stays 1 while fewer than two unread narrow words exist, so an odd leftover word is never offered.
- R6: A wide read pops both FIFOs in the same cycle, and their read pointers stay equal.
- R7: A read is accepted when rd_en is 1 and rd_empty is 0. A read attempted while rd_empty is 1 has no effect: no rd_ack, and the stored words are kept.
- R8: While rd_empty is 0, rd_data shows the oldest unread pair without needing a request. rd_ack is 1 in the rd_clk cycle that follows an accepted read.
- R9: Once the pointer crossings have settled, wr_count equals the number of narrow words written minus twice the wide words read. It never exceeds twice the per-FIFO depth.
- R10: wr_full reflects the FIFO targeted by the next write. With depth D per FIFO and no reads, it is 0 after 2D-1 writes and 1 after 2D writes.
- R11: After reset, wr_full is 0, wr_count is 0, rd_empty is 1, and both acknowledges are 0.
- R12: Word order and content are preserved across pointer wrap-around when writes and reads run concurrently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Narrow-side clock |
| wr_rst_n | input | 1 | Narrow-side reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Narrow word to store |
| wr_ack | output | 1 | Previous-cycle write was accepted |
| wr_full | output | 1 | FIFO targeted by the next write is full |
| wr_count | output | AW+2 (5) | Occupancy in narrow words, write-side view |
| rd_clk | input | 1 | Wide-side clock |
| rd_rst_n | input | 1 | Wide-side reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | 64 | Oldest pair, high half = later word |
| rd_ack | output | 1 | Previous-cycle read was accepted |
| rd_empty | output | 1 | No complete wide word available |

## Verification
The embedded properties assume two things about the inputs. The two resets are held long enough for both synchronizers to settle. The clocks are free-running, so the Gray pointers can make progress. They also take for granted that the top gates every request with its own status flag, so a FIFO below never sees a write while full or a read while empty.

The stimulus respects this by sampling wr_full or rd_empty before each request. It deliberately issues requests against full and empty, checking that they are dropped. It waits several cycles of the opposite clock before comparing the settled count and flags against the queue model.

// File: rtl/nw_pkg.sv
package nw_pkg;
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/nw_sync2.sv
module nw_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/nw_gray_fifo.sv
module nw_gray_fifo #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  output logic [AW:0]   wlevel,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  output logic [DW-1:0] rdata,
  output logic          rempty,
  output logic [AW:0]   rptr
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [AW:0] rgray_w, wgray_r;

  // write domain
  always_comb begin
    wbin_d  = wbin_q + {{AW{1'b0}}, 1'b1};
    wgray_d = to_gray(wbin_d);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (we) mem[wbin_q[AW-1:0]] <= wdata;
  end

  nw_sync2 #(.W(AW + 1)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w)
  );

  assign wfull  = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign wlevel = wbin_q - from_gray(rgray_w);

  // read domain
  always_comb begin
    rbin_d  = rbin_q + {{AW{1'b0}}, 1'b1};
    rgray_d = to_gray(rbin_d);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (re) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  nw_sync2 #(.W(AW + 1)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r)
  );

  assign rempty = (rgray_q == wgray_r);
  assign rdata  = mem[rbin_q[AW-1:0]];
  assign rptr   = rbin_q;

  // R3: upstream never writes a full FIFO
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    we |-> !wfull);
  // R7: upstream never pops an empty FIFO
  p_no_underflow_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    re |-> !rempty);
  // R9: per-FIFO occupancy bounded by depth
  p_level_bound_r9: assert property (@(posedge wclk) disable iff (!wrst_n)
    wlevel <= (AW+1)'(DEPTH));
endmodule

// File: rtl/nw_lane_steer.sv
module nw_lane_steer
  import nw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic full_lo,
  input  logic full_hi,
  output logic we_lo,
  output logic we_hi,
  output logic full_sel,
  output logic accept
);
  lane_e lane_q, lane_d;

  always_comb begin
    full_sel = (lane_q == LANE_LO) ? full_lo : full_hi;
    accept   = wr_en & ~full_sel;
    we_lo    = accept & (lane_q == LANE_LO);
    we_hi    = accept & (lane_q == LANE_HI);
    lane_d   = (lane_q == LANE_LO) ? LANE_HI : LANE_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lane_q <= LANE_LO;
    else if (accept) lane_q <= lane_d;
  end

  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> lane_q != $past(lane_q));
  p_lane_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(lane_q));
  p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_lo, we_hi}));
endmodule

// File: rtl/nw_fifo_pair.sv
module nw_fifo_pair #(
  parameter int HALF_W = 32,
  parameter int AW     = 3
) (
  input  logic                wr_clk,
  input  logic                wr_rst_n,
  input  logic                wr_en,
  input  logic [HALF_W-1:0]   wr_data,
  output logic                wr_ack,
  output logic                wr_full,
  output logic [AW+1:0]       wr_count,
  input  logic                rd_clk,
  input  logic                rd_rst_n,
  input  logic                rd_en,
  output logic [2*HALF_W-1:0] rd_data,
  output logic                rd_ack,
  output logic                rd_empty
);
  localparam int CW    = AW + 2;
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] CAP = CW'(2 * DEPTH);

  // reset synchronizers: async assert, sync release
  logic [1:0] wrst_q, rrst_q;
  logic       wrst_s, rrst_s;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) wrst_q <= 2'b00;
    else           wrst_q <= {wrst_q[0], 1'b1};
  end
  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rrst_q <= 2'b00;
    else           rrst_q <= {rrst_q[0], 1'b1};
  end
  assign wrst_s = wrst_q[1];
  assign rrst_s = rrst_q[1];

  logic             we_lo, we_hi, accept, full_sel;
  logic [1:0]       full_v, empty_v;
  logic [AW:0]      level_v [2];
  logic [AW:0]      rptr_v  [2];
  logic [HALF_W-1:0] rdata_v [2];
  logic [1:0]       we_v;
  logic             rd_pop;
  logic             wr_ack_d, rd_ack_d;

  nw_lane_steer u_steer (
    .clk(wr_clk), .rst_n(wrst_s), .wr_en(wr_en),
    .full_lo(full_v[0]), .full_hi(full_v[1]),
    .we_lo(we_lo), .we_hi(we_hi), .full_sel(full_sel), .accept(accept)
  );

  assign we_v = {we_hi, we_lo};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_half
      nw_gray_fifo #(.DW(HALF_W), .AW(AW)) u_fifo (
        .wclk(wr_clk), .wrst_n(wrst_s), .we(we_v[g]), .wdata(wr_data),
        .wfull(full_v[g]), .wlevel(level_v[g]),
        .rclk(rd_clk), .rrst_n(rrst_s), .re(rd_pop),
        .rdata(rdata_v[g]), .rempty(empty_v[g]), .rptr(rptr_v[g])
      );
    end
  endgenerate

  always_comb begin
    rd_empty = |empty_v;
    rd_pop   = rd_en & ~rd_empty;
    rd_data  = {rdata_v[1], rdata_v[0]};
    wr_full  = full_sel;
    wr_count = {1'b0, level_v[0]} + {1'b0, level_v[1]};
    wr_ack_d = accept;
    rd_ack_d = rd_pop;
  end

  always_ff @(posedge wr_clk or negedge wrst_s) begin
    if (!wrst_s) wr_ack <= 1'b0;
    else         wr_ack <= wr_ack_d;
  end

  always_ff @(posedge rd_clk or negedge rrst_s) begin
    if (!rrst_s) rd_ack <= 1'b0;
    else         rd_ack <= rd_ack_d;
  end

  p_drop_when_full_r3: assert property (@(posedge wr_clk) disable iff (!wrst_s)
    (wr_en && wr_full) |=> !wr_ack);
  p_ack_follows_req_r4: assert property (@(posedge wr_clk) disable iff (!wrst_s)
    wr_ack |-> $past(wr_en));
  p_lockstep_r6: assert property (@(posedge rd_clk) disable iff (!rrst_s)
    rptr_v[0] == rptr_v[1]);
  p_no_read_empty_r7: assert property (@(posedge rd_clk) disable iff (!rrst_s)
    (rd_en && rd_empty) |=> !rd_ack);
  p_rd_ack_r8: assert property (@(posedge rd_clk) disable iff (!rrst_s)
    rd_ack |-> $past(rd_en));
  p_count_bound_r9: assert property (@(posedge wr_clk) disable iff (!wrst_s)
    wr_count <= CAP);
  p_full_at_cap_r10: assert property (@(posedge wr_clk) disable iff (!wrst_s)
    (wr_count == CAP) |-> wr_full);
endmodule

// File: tb/nw_fifo_pair_tb.sv
module nw_fifo_pair_tb;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int CAP   = 2 * DEPTH;

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst_n, rd_rst_n, wr_en, rd_en;
  logic [31:0] wr_data;
  logic        wr_ack, wr_full, rd_ack, rd_empty;
  logic [AW+1:0] wr_count;
  logic [63:0] rd_data;

  int checks = 0;
  int errors = 0;
  int pairs  = 0;
  logic [31:0] wq[$];

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  nw_fifo_pair #(.HALF_W(32), .AW(AW)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_full(wr_full), .wr_count(wr_count),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_ack(rd_ack), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] d);
    bit acc;
    @(negedge wr_clk);
    if (wq.size() >= CAP) check(wr_full == 1'b1, "R10", "full at capacity", wr_full, 1);
    acc = !wr_full;
    wr_en = 1'b1;
    wr_data = d;
    if (acc) wq.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
    check(wr_ack == acc, "R4", "write ack", wr_ack, acc);
  endtask

  task automatic rd_pair(input bit req);
    bit av;
    @(negedge rd_clk);
    av = !rd_empty && req;
    if (wq.size() < 2) check(rd_empty == 1'b1, "R5", "empty with no full pair", rd_empty, 1);
    if (!rd_empty)
      check(rd_data == {wq[1], wq[0]}, "R1", "wide word", rd_data, {wq[1], wq[0]});
    rd_en = req;
    if (av) begin
      void'(wq.pop_front());
      void'(wq.pop_front());
      pairs++;
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
    check(rd_ack == av, "R8", "read ack", rd_ack, av);
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * WR_PERIOD);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    #(3 * RD_PERIOD);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);

    // R11 reset state
    check(wr_full == 1'b0, "R11", "wr_full", wr_full, 0);
    check(wr_count == 0, "R11", "wr_count", wr_count, 0);
    check(rd_empty == 1'b1, "R11", "rd_empty", rd_empty, 1);
    check(wr_ack == 1'b0, "R11", "wr_ack", wr_ack, 0);
    check(rd_ack == 1'b0, "R11", "rd_ack", rd_ack, 0);

    // R5 single word is not offered; R1 pair ordering
    wr_word(32'hA000_0001);
    settle();
    check(rd_empty == 1'b1, "R5", "one word stays hidden", rd_empty, 1);
    wr_word(32'hB000_0002);
    settle();
    check(rd_empty == 1'b0, "R5", "pair visible", rd_empty, 0);
    check(rd_data == 64'hB000_0002_A000_0001, "R1", "low/high halves", rd_data, 64'hB000_0002_A000_0001);
    check(wr_count == 2, "R9", "count two", wr_count, 2);

    for (int i = 0; i < 3; i++) wr_word(32'hC000_0000 + i);
    settle();
    check(wr_count == 5, "R9", "count five", wr_count, 5);
    rd_pair(1'b1);
    rd_pair(1'b1);
    settle();
    check(rd_empty == 1'b1, "R5", "odd leftover hidden", rd_empty, 1);
    check(wr_count == 1, "R9", "count one", wr_count, 1);

    // R7 read on empty ignored
    rd_pair(1'b1);
    settle();
    check(wr_count == 1, "R7", "no pop on empty", wr_count, 1);
    wr_word(32'hD000_0009);
    settle();
    check(rd_data == {32'hD000_0009, 32'hC000_0002}, "R7", "leftover kept",
          rd_data, {32'hD000_0009, 32'hC000_0002});
    rd_pair(1'b1);
    settle();

    // R10 full tracks targeted FIFO
    for (int i = 0; i < CAP - 1; i++) wr_word(32'hE000_0000 + i);
    settle();
    check(wr_full == 1'b0, "R10", "2D-1 words not full", wr_full, 0);
    check(wr_count == CAP - 1, "R9", "count 2D-1", wr_count, CAP - 1);
    wr_word(32'hE000_00FF);
    settle();
    check(wr_full == 1'b1, "R10", "2D words full", wr_full, 1);
    check(wr_count == CAP, "R9", "count at capacity", wr_count, CAP);

    // R3 write while full dropped
    wr_word(32'hDEAD_BEEF);
    settle();
    check(wr_count == CAP, "R3", "count unchanged", wr_count, CAP);
    for (int i = 0; i < DEPTH; i++) rd_pair(1'b1);
    settle();
    check(rd_empty == 1'b1, "R3", "dropped word absent", rd_empty, 1);
    check(wr_count == 0, "R9", "drained count", wr_count, 0);
    check(wr_full == 1'b0, "R10", "drained full", wr_full, 0);

    // R12 concurrent traffic across wrap
    pairs = 0;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          wr_word(32'h1000_0000 + i);
          if ($urandom_range(0, 3) == 0) @(negedge wr_clk);
        end
      end
      begin
        while (pairs < 150) rd_pair($urandom_range(0, 4) != 0);
      end
    join
    settle();
    check(pairs == 150, "R12", "pairs received", pairs, 150);
    check(wr_count == 0, "R12", "count after stream", wr_count, 0);
    check(rd_empty == 1'b1, "R12", "empty after stream", rd_empty, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule